// File: doc/BRIEF.md
# Branch Condition and Next-PC Select

This block is the control-flow heart of a processor that completes one instruction per clock. It holds the program counter and a three-bit flag register with zero, sign and overflow flags. Every clock it looks at the current instruction's opcode and function field and decides where the next instruction comes from. There are four possible sources: the sequential address, a branch target, a call target, or a return address that the data memory has just read from the stack. The same condition evaluator decides whether a conditional jump is taken and whether a conditional register move commits. Its result is brought out so that the register-file write path can cancel a move whose condition fails.

The flags change only when an arithmetic/logic instruction executes. They are taken from that instruction's ALU result and overflow bit. A halt opcode, an undefined opcode, an undefined condition code on a jump or move, or the external halt request stops the machine. The program counter and flags then freeze, and a halted output stays high until reset. All arithmetic on addresses (valP, valC) and the memory read (valM) happen outside; this block only selects among them.

Top module: `branch_pc_unit`

## Requirements
- R1: After reset the PC reads 0, halted is 0, and the flags are zero-flag 1, sign-flag 0, overflow-flag 0.
- R2: The condition output depends only on the function field and the current flags: 0 always true, 1 (S xor O) or Z, 2 S xor O, 3 Z, 4 not Z, 5 not (S xor O), 6 not (S xor O) and not Z; function values 7 to 15 give 0.
- R3: An arithmetic/logic instruction (opcode 6) loads Z = (result == 0), S = most significant result bit, O = the overflow input, visible from the next cycle.
- R4: Every opcode other than 6 leaves the flags unchanged, whatever the ALU inputs carry.
- R5: A jump (opcode 7) loads valC into the PC when the condition of its function field holds, and valP otherwise.
- R6: A call (opcode 8) loads valC into the PC unconditionally.
- R7: A return (opcode 9) loads valM into the PC.
- R8: Opcodes 1 to 6 and 10 to 11 load valP into the PC.
- R9: Opcode 0, opcodes 12 to 15, opcode 2 or 7 with a function field above 6, or the halt request input leaves the PC and flags at their values. In that case halted rises on the next clock.
- R10: Once halted is 1 it stays 1 until reset, and the PC and flags ignore every input while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Opcode of the current instruction |
| func | input | 4 | Function field (condition code for jumps and moves) |
| alu_result | input | DATA_W | ALU result of the current instruction |
| alu_ovf | input | 1 | Signed overflow of the current ALU operation |
| valc | input | ADDR_W | Constant word from the instruction (branch/call target) |
| valp | input | ADDR_W | Address of the sequentially next instruction |
| valm | input | ADDR_W | Word read from data memory (return address) |
| halt_req | input | 1 | External request to stop the machine |
| cond_true | output | 1 | Condition of the function field holds on the current flags |
| pc | output | ADDR_W | Current program counter |
| halted | output | 1 | Machine stopped; sticky until reset |

## Verification
The hardest conditions to reach from the ports are the flag combinations, because the flags cannot be written directly. They can only be loaded through an arithmetic instruction, and a zero result can never carry a set sign bit. The stimulus therefore cycles through the six reachable combinations (zero or positive or negative result, each with and without overflow). After each one it sweeps every function field, once as a combinational probe and once as a real jump whose PC is checked. Immunity while halted is observed the same way: arithmetic and call instructions are issued after a stop, and then the probe shows unchanged flags and the PC shows no movement.

// File: rtl/branch_pc_pkg.sv
package branch_pc_pkg;

  localparam logic [3:0] OPC_HALT  = 4'h0;
  localparam logic [3:0] OPC_NOP   = 4'h1;
  localparam logic [3:0] OPC_CMOV  = 4'h2;
  localparam logic [3:0] OPC_IRMOV = 4'h3;
  localparam logic [3:0] OPC_RMMOV = 4'h4;
  localparam logic [3:0] OPC_MRMOV = 4'h5;
  localparam logic [3:0] OPC_ALU   = 4'h6;
  localparam logic [3:0] OPC_JUMP  = 4'h7;
  localparam logic [3:0] OPC_CALL  = 4'h8;
  localparam logic [3:0] OPC_RET   = 4'h9;
  localparam logic [3:0] OPC_PUSH  = 4'hA;
  localparam logic [3:0] OPC_POP   = 4'hB;
  localparam logic [3:0] OPC_LAST  = OPC_POP;

  localparam logic [3:0] CND_ALWAYS = 4'd0;
  localparam logic [3:0] CND_LE     = 4'd1;
  localparam logic [3:0] CND_LT     = 4'd2;
  localparam logic [3:0] CND_EQ     = 4'd3;
  localparam logic [3:0] CND_NE     = 4'd4;
  localparam logic [3:0] CND_GE     = 4'd5;
  localparam logic [3:0] CND_GT     = 4'd6;
  localparam logic [3:0] CND_LAST   = CND_GT;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_CALL   = 2'd2,
    SRC_RET    = 2'd3
  } pc_src_e;

endpackage

// File: rtl/bpu_decode.sv
module bpu_decode
  import branch_pc_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic [3:0] func,
  input  logic       halt_req,
  output pc_src_e    pc_src,
  output logic       is_alu,
  output logic       stop
);

  logic uses_cond;
  logic bad_opcode;
  logic bad_cond;

  assign uses_cond  = (opcode == OPC_CMOV) || (opcode == OPC_JUMP);
  assign bad_opcode = (opcode > OPC_LAST);
  assign bad_cond   = uses_cond && (func > CND_LAST);
  assign stop       = halt_req || (opcode == OPC_HALT) || bad_opcode || bad_cond;
  assign is_alu     = (opcode == OPC_ALU);

  always_comb begin
    unique case (opcode)
      OPC_JUMP: pc_src = SRC_BRANCH;
      OPC_CALL: pc_src = SRC_CALL;
      OPC_RET:  pc_src = SRC_RET;
      default:  pc_src = SRC_SEQ;
    endcase
  end

endmodule

// File: rtl/bpu_cond_eval.sv
module bpu_cond_eval
  import branch_pc_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] func,
  output logic       cond
);

  logic less;

  assign less = flags.sf ^ flags.of;

  always_comb begin
    case (func)
      CND_ALWAYS: cond = 1'b1;
      CND_LE:     cond = less | flags.zf;
      CND_LT:     cond = less;
      CND_EQ:     cond = flags.zf;
      CND_NE:     cond = ~flags.zf;
      CND_GE:     cond = ~less;
      CND_GT:     cond = ~less & ~flags.zf;
      default:    cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/bpu_flag_reg.sv
module bpu_flag_reg
  import branch_pc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] result,
  input  logic              ovf,
  output flags_t            flags
);

  localparam int SIGN_BIT = DATA_W - 1;

  flags_t flags_d;

  assign flags_d.zf = (result == '0);
  assign flags_d.sf = result[SIGN_BIT];
  assign flags_d.of = ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags <= FLAGS_RESET;
    else if (upd_en) flags <= flags_d;
  end

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags));

  // R3
  flags_zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> !(flags.zf && flags.sf));

endmodule

// File: rtl/bpu_pc_select.sv
module bpu_pc_select
  import branch_pc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  pc_src_e           pc_src,
  input  logic              cond,
  input  logic [ADDR_W-1:0] valc,
  input  logic [ADDR_W-1:0] valp,
  input  logic [ADDR_W-1:0] valm,
  output logic [ADDR_W-1:0] next_pc
);

  always_comb begin
    unique case (pc_src)
      SRC_BRANCH: next_pc = cond ? valc : valp;
      SRC_CALL:   next_pc = valc;
      SRC_RET:    next_pc = valm;
      default:    next_pc = valp;
    endcase
  end

endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import branch_pc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        opcode,
  input  logic [3:0]        func,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_ovf,
  input  logic [ADDR_W-1:0] valc,
  input  logic [ADDR_W-1:0] valp,
  input  logic [ADDR_W-1:0] valm,
  input  logic              halt_req,
  output logic              cond_true,
  output logic [ADDR_W-1:0] pc,
  output logic              halted
);

  pc_src_e           pc_src;
  logic              is_alu;
  logic              stop;
  logic              exec;
  flags_t            flags;
  logic [ADDR_W-1:0] next_pc;

  bpu_decode u_decode (
    .opcode   (opcode),
    .func     (func),
    .halt_req (halt_req),
    .pc_src   (pc_src),
    .is_alu   (is_alu),
    .stop     (stop)
  );

  assign exec = !halted && !stop;

  bpu_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (exec && is_alu),
    .result (alu_result),
    .ovf    (alu_ovf),
    .flags  (flags)
  );

  bpu_cond_eval u_cond (
    .flags (flags),
    .func  (func),
    .cond  (cond_true)
  );

  bpu_pc_select #(.ADDR_W(ADDR_W)) u_sel (
    .pc_src  (pc_src),
    .cond    (cond_true),
    .valc    (valc),
    .valp    (valp),
    .valm    (valm),
    .next_pc (next_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (exec) pc <= next_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                halted <= 1'b0;
    else if (!halted && stop)  halted <= 1'b1;
  end

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc));

  // R9
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && opcode == OPC_HALT) |=> (halted && $stable(pc)));

  // R6
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_req && opcode == OPC_CALL) |=> (pc == $past(valc)));

  // R7
  ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_req && opcode == OPC_RET) |=> (pc == $past(valm)));

  // R5
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_req && opcode == OPC_JUMP && func <= CND_LAST && cond_true)
      |=> (pc == $past(valc)));

endmodule

// File: tb/branch_pc_unit_bench.sv
`timescale 1ns/100ps
module branch_pc_unit_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   opcode = 4'h1;
  logic [3:0]   func = 4'h0;
  logic [W-1:0] alu_result = '0;
  logic         alu_ovf = 1'b0;
  logic [W-1:0] valc = '0;
  logic [W-1:0] valp = '0;
  logic [W-1:0] valm = '0;
  logic         halt_req = 1'b0;
  logic         cond_true;
  logic [W-1:0] pc;
  logic         halted;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] pc_m;
  logic zf_m, sf_m, of_m, h_m;

  always #2.5 clk = ~clk;

  branch_pc_unit #(.DATA_W(W), .ADDR_W(W)) u_branch_pc_unit (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .func(func),
    .alu_result(alu_result), .alu_ovf(alu_ovf), .valc(valc), .valp(valp),
    .valm(valm), .halt_req(halt_req), .cond_true(cond_true), .pc(pc),
    .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_of(input logic [3:0] f);
    logic lt;
    lt = sf_m ^ of_m;
    case (f)
      4'd0: return 1'b1;
      4'd1: return lt | zf_m;
      4'd2: return lt;
      4'd3: return zf_m;
      4'd4: return ~zf_m;
      4'd5: return ~lt;
      4'd6: return ~lt & ~zf_m;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] ilen(input logic [3:0] op);
    case (op)
      4'h2, 4'h6, 4'hA, 4'hB: return 16'd2;
      4'h3, 4'h4, 4'h5:       return 16'd10;
      4'h7, 4'h8:             return 16'd9;
      default:                return 16'd1;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    opcode = 4'h1; func = 4'h0; halt_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    pc_m = '0; zf_m = 1'b1; sf_m = 1'b0; of_m = 1'b0; h_m = 1'b0;
    chk(pc == 16'h0, "R1 pc after reset", pc, 16'h0);
    chk(halted == 1'b0, "R1 halted after reset", {15'b0, halted}, 16'h0);
  endtask

  // combinational sweep of every function value; called at a negedge
  task automatic probe(input string req);
    opcode = 4'h1;
    for (int f = 0; f < 16; f++) begin
      func = 4'(f);
      #0.1;
      chk(cond_true == cond_of(4'(f)), req, {15'b0, cond_true},
          {15'b0, cond_of(4'(f))});
    end
    func = 4'h0;
  endtask

  task automatic step(input logic [3:0] op, input logic [3:0] fn,
                      input logic [W-1:0] res, input logic ovf,
                      input logic [W-1:0] c, input logic [W-1:0] m,
                      input logic hreq, input string req);
    logic stop;
    logic cnd;
    logic [W-1:0] npc;
    opcode = op; func = fn; alu_result = res; alu_ovf = ovf;
    valc = c; valm = m; halt_req = hreq;
    valp = pc_m + ilen(op);
    #0.5;
    cnd = cond_of(fn);
    chk(cond_true == cnd, "R2 condition output", {15'b0, cond_true}, {15'b0, cnd});
    stop = hreq || op == 4'h0 || op > 4'hB || ((op == 4'h2 || op == 4'h7) && fn > 4'd6);
    case (op)
      4'h7:    npc = cnd ? c : valp;
      4'h8:    npc = c;
      4'h9:    npc = m;
      default: npc = valp;
    endcase
    @(posedge clk);
    if (!h_m) begin
      if (stop) h_m = 1'b1;
      else begin
        pc_m = npc;
        if (op == 4'h6) begin
          zf_m = (res == '0); sf_m = res[W-1]; of_m = ovf;
        end
      end
    end
    @(negedge clk);
    halt_req = 1'b0;
    chk(pc == pc_m, req, pc, pc_m);
    chk(halted == h_m, "R9 R10 halted output", {15'b0, halted}, {15'b0, h_m});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] res_tab [6];
    logic         ovf_tab [6];
    res_tab = '{16'h0000, 16'h0000, 16'h0042, 16'h0042, 16'h8001, 16'h8001};
    ovf_tab = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    // R1: reset values, flags observed through the evaluator
    do_reset();
    probe("R1 R2 reset flags");

    // R3 R5 R2: each reachable flag combination, then every jump condition
    for (int i = 0; i < 6; i++) begin
      step(4'h6, 4'h0, res_tab[i], ovf_tab[i], 16'h0, 16'h0, 1'b0, "R8 R3 alu step");
      probe("R3 flags from alu");
      for (int f = 0; f < 7; f++) begin
        step(4'h7, 4'(f), 16'h0, 1'b0, 16'h4000 + 16'(i * 256 + f * 16),
             16'h0, 1'b0, "R5 jump target");
      end
    end

    // R4 R8: non-alu opcodes with misleading ALU inputs
    step(4'h6, 4'h0, 16'h8001, 1'b1, 16'h0, 16'h0, 1'b0, "R8 alu step");
    for (int k = 1; k < 12; k++) begin
      if (k == 6 || k == 7 || k == 8 || k == 9) continue;
      step(4'(k), 4'd6, 16'h0000, 1'b0, 16'h7777, 16'h6666, 1'b0, "R8 sequential pc");
    end
    probe("R4 flags unchanged");

    // R6 R7: call and return
    step(4'h8, 4'h0, 16'h0, 1'b0, 16'h2468, 16'h0, 1'b0, "R6 call target");
    step(4'h9, 4'h0, 16'h0, 1'b0, 16'h0, 16'h1357, 1'b0, "R7 return address");
    step(4'h8, 4'h3, 16'h0, 1'b0, 16'h0FF0, 16'hAAAA, 1'b0, "R6 call target");
    step(4'h9, 4'h3, 16'h0, 1'b0, 16'h5555, 16'h3210, 1'b0, "R7 return address");

    // R9 R10: undefined jump condition, then inputs ignored
    step(4'h7, 4'd9, 16'h0, 1'b0, 16'h1111, 16'h0, 1'b0, "R9 pc holds");
    step(4'h8, 4'h0, 16'h0, 1'b0, 16'h2222, 16'h0, 1'b0, "R10 pc frozen");
    step(4'h6, 4'h0, 16'h0000, 1'b0, 16'h0, 16'h0, 1'b0, "R10 pc frozen");
    step(4'h9, 4'h0, 16'h0, 1'b0, 16'h0, 16'h3333, 1'b0, "R10 pc frozen");
    probe("R10 flags frozen");

    // R9: each stop cause
    do_reset();
    step(4'h8, 4'h0, 16'h0, 1'b0, 16'h0100, 16'h0, 1'b0, "R6 call target");
    step(4'h0, 4'h0, 16'h0, 1'b0, 16'h9999, 16'h0, 1'b0, "R9 halt opcode");
    do_reset();
    step(4'h6, 4'h0, 16'h0042, 1'b1, 16'h0, 16'h0, 1'b0, "R3 alu step");
    step(4'hC, 4'h0, 16'h0, 1'b0, 16'h9999, 16'h0, 1'b0, "R9 undefined opcode");
    step(4'hF, 4'h0, 16'h0, 1'b0, 16'h9999, 16'h0, 1'b0, "R10 pc frozen");
    probe("R10 flags frozen");
    do_reset();
    step(4'h2, 4'd7, 16'h0, 1'b0, 16'h9999, 16'h0, 1'b0, "R9 undefined move cond");
    do_reset();
    step(4'h6, 4'h0, 16'h8001, 1'b0, 16'h0, 16'h0, 1'b1, "R9 halt request");
    probe("R9 flags held on stop");
    step(4'h1, 4'h0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, "R10 pc frozen");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule